// File: doc/BRIEF.md
# SIR Infrared Pulse Modulator with Deferred PHY Settings

This block turns a serial bit stream into return-to-zero infrared pulses for the slow infrared link. At the start of every bit period the block asks for one line bit. A 0 bit, start bits included, produces one light pulse at the start of its period. A 1 bit produces no pulse. Bit timing and pulse width come from a 16-bit PHY word. This word holds a divisor field BAUD in bits [15:10], a width field PLSWID in bits [9:5] and a preamble field PREAMB in bits [4:0]. All of them count ticks of an external reference strobe, which runs at 8 MHz, or at 16 MHz when the primary clock is 48 MHz.

Software writes a pending PHY word and a mode word at any time. Neither takes effect until the PHY enable goes from 0 to 1. On that edge, the pending word and the three mode bits are copied into the applied set. The applied word can be read back. A status word reports the enable, a mode conflict, the mode now on, and the effective transmit and receive enables. Only the SIR mode drives the modulator. The MIR and FIR selections only show up in status.

A state machine has four states. OFF means the modulator is idle. MARK is a 1 bit. PULSE is the lit part of a 0 bit. SPACE is the dark remainder of a 0 bit. The transitions are as follows:
- OFF→PULSE or OFF→MARK happens when the block starts running, depending on the sampled bit.
- MARK, PULSE or SPACE go to PULSE or MARK at every bit boundary.
- PULSE→SPACE happens when the width count expires.
- Any state goes to OFF when running stops.

Top module: `sir_pulse_tx`

## Requirements
- R1: After reset, ir_out, bit_strobe, phy_cur and status are all 0.
- R2: A pending-word write is accepted at any time. On the cycle of a 0→1 enable write, phy_cur loads the pending value held before that cycle. At all other times phy_cur keeps its value, including after pending writes made while enabled.
- R3: cfg_wdata bit 0 selects SIR, bit 1 MIR and bit 2 FIR. These bits are applied only on the enable rising edge. While the enable is on, status bit 11 shows SIR on, bit 12 MIR on and bit 13 FIR on, each from the applied bits.
- R4: When the enable is on and more than one applied mode bit is set, status bit 14 is 1, status bits 13:11 are 0 and no bit is modulated.
- R5: Status bit 15 is the applied enable. Bit 10 is cfg_wdata bit 3 (transmit enable). Bit 9 is cfg bit 4 (receive enable) AND (NOT transmit enable OR cfg bit 5, loopback). Bits 8:0 read 0.
- R6: The block runs while the enable is on, SIR is on and transmit is enabled. bit_strobe is high for one cycle in the first running cycle, and then once every BIT_UNITS×(BAUD+1) ref_tick pulses. ser_in is sampled in that cycle.
- R7: For a sampled 0, the pulse starts on the cycle after bit_strobe and lasts (PLSWID+1)×(BAUD+1) ref_tick pulses. For a sampled 1 there is no pulse. PREAMB has no effect.
- R8: When PLSWID+1 ≥ BIT_UNITS, the pulse is cut at the bit boundary, and the next bit starts fresh.
- R9: cfg_wdata bit 6 inverts ir_out at all times, including when idle. It acts live, not on the enable edge.
- R10: Timing counts only cycles with ref_tick high. With ref_tick low the timing state holds.
- R11: When the running condition drops, ir_out returns to its idle level one cycle after the register change, even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ref_tick | input | 1 | One-cycle strobe of the 8/16 MHz reference |
| nphy_we | input | 1 | Write strobe for the pending PHY word |
| nphy_wdata | input | 16 | Pending PHY word {BAUD, PLSWID, PREAMB} |
| cfg_we | input | 1 | Write strobe for the mode word |
| cfg_wdata | input | 7 | {inv, loop, rx_en, tx_en, fir, mir, sir} |
| en_we | input | 1 | Write strobe for the PHY enable |
| en_wdata | input | 1 | New PHY enable value |
| ser_in | input | 1 | Serial line bit, sampled on bit_strobe |
| bit_strobe | output | 1 | Bit request/sample strobe |
| ir_out | output | 1 | Infrared pulse line |
| phy_cur | output | 16 | Applied PHY word read-back |
| status | output | 16 | Enable and status word |

## Verification
The bench builds the block with BIT_UNITS at 5 instead of 69. This keeps a bit period at a few cycles. It also lets a width of 8 units exceed the bit period, so the truncation case in R8 is reachable without long runs. Divisors of 1, 2 and 3 are run with ref_tick high on every cycle and on every third cycle. This covers the tick scaling and the gating of the counters by ref_tick.

// File: rtl/sir_pkg.sv
package sir_pkg;
    localparam int WORD_W  = 16;
    localparam int DIV_LSB = 10;
    localparam int DIV_W   = 6;
    localparam int WID_LSB = 5;
    localparam int WID_W   = 5;
    localparam int CFG_W   = 7;

    // mode word bit positions
    localparam int C_SIR  = 0;
    localparam int C_MIR  = 1;
    localparam int C_FIR  = 2;
    localparam int C_TX   = 3;
    localparam int C_RX   = 4;
    localparam int C_LOOP = 5;
    localparam int C_INV  = 6;

    // status bit positions
    localparam int S_EN    = 15;
    localparam int S_ERR   = 14;
    localparam int S_FIR   = 13;
    localparam int S_MIR   = 12;
    localparam int S_SIR   = 11;
    localparam int S_TXST  = 10;
    localparam int S_RXST  = 9;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_MARK,
        ST_PULSE,
        ST_SPACE
    } tx_state_e;
endpackage

// File: rtl/sir_cfg_regs.sv
module sir_cfg_regs
    import sir_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nphy_we,
    input  logic [WORD_W-1:0]   nphy_wdata,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                en_we,
    input  logic                en_wdata,
    output logic [WORD_W-1:0]   nphy_q,
    output logic [WORD_W-1:0]   phy_cur,
    output logic                tx_en,
    output logic                tx_inv,
    output logic [WORD_W-1:0]   status
);
    logic [CFG_W-1:0] cfg_q;
    logic [2:0]       mode_q;
    logic             en_q;
    logic             clash;
    logic [2:0]       mode_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nphy_q  <= '0;
            phy_cur <= '0;
            cfg_q   <= '0;
            mode_q  <= '0;
            en_q    <= 1'b0;
        end else begin
            // apply uses values held before this cycle
            if (en_we) begin
                if (en_wdata && !en_q) begin
                    phy_cur <= nphy_q;
                    mode_q  <= cfg_q[C_FIR:C_SIR];
                end
                en_q <= en_wdata;
            end
            if (nphy_we) nphy_q <= nphy_wdata;
            if (cfg_we)  cfg_q  <= cfg_wdata;
        end
    end

    always_comb begin
        clash   = en_q && ($countones(mode_q) > 1);
        mode_on = (en_q && !clash) ? mode_q : 3'b000;
        status          = '0;
        status[S_EN]    = en_q;
        status[S_ERR]   = clash;
        status[S_FIR]   = mode_on[2];
        status[S_MIR]   = mode_on[1];
        status[S_SIR]   = mode_on[0];
        status[S_TXST]  = cfg_q[C_TX];
        status[S_RXST]  = cfg_q[C_RX] && (!cfg_q[C_TX] || cfg_q[C_LOOP]);
    end

    assign tx_en  = cfg_q[C_TX];
    assign tx_inv = cfg_q[C_INV];
endmodule

// File: rtl/sir_unit_timer.sv
module sir_unit_timer
    import sir_pkg::*;
#(
    parameter int BIT_UNITS = 69,
    localparam int IDX_W = (BIT_UNITS > 2) ? $clog2(BIT_UNITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ref_tick,
    input  logic [DIV_W-1:0] div,
    output logic             unit_end,
    output logic [IDX_W-1:0] unit_idx
);
    logic [DIV_W-1:0] tick_cnt;

    assign unit_end = ref_tick && (tick_cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            unit_idx <= '0;
        end else if (clr) begin
            tick_cnt <= '0;
            unit_idx <= '0;
        end else if (ref_tick) begin
            if (tick_cnt == div) begin
                tick_cnt <= '0;
                unit_idx <= (unit_idx == IDX_W'(BIT_UNITS - 1)) ? '0 : unit_idx + 1'b1;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sir_pulse_fsm.sv
module sir_pulse_fsm
    import sir_pkg::*;
#(
    parameter int BIT_UNITS = 69,
    localparam int IDX_W = (BIT_UNITS > 2) ? $clog2(BIT_UNITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ser_in,
    input  logic             unit_end,
    input  logic [IDX_W-1:0] unit_idx,
    input  logic [WID_W-1:0] width,
    output logic             bit_strobe,
    output logic             pulse_on,
    output logic             clr
);
    tx_state_e state, nxt;
    logic      bit_end;
    logic      width_done;

    assign bit_end    = unit_end && (unit_idx == IDX_W'(BIT_UNITS - 1));
    assign width_done = unit_end && (32'(unit_idx) == 32'(width));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   nxt = ser_in ? ST_MARK : ST_PULSE;
            ST_MARK,
            ST_SPACE: if (bit_end) nxt = ser_in ? ST_MARK : ST_PULSE;
            ST_PULSE: begin
                if (bit_end)         nxt = ser_in ? ST_MARK : ST_PULSE;
                else if (width_done) nxt = ST_SPACE;
            end
        endcase
        if (!run) nxt = ST_OFF;
    end

    always_comb begin
        bit_strobe = run && ((state == ST_OFF) || bit_end);
        pulse_on   = (state == ST_PULSE);
        clr        = (state == ST_OFF);
    end
endmodule

// File: rtl/sir_pulse_tx.sv
module sir_pulse_tx
    import sir_pkg::*;
#(
    parameter int BIT_UNITS = 69,
    localparam int IDX_W = (BIT_UNITS > 2) ? $clog2(BIT_UNITS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_tick,
    input  logic                nphy_we,
    input  logic [WORD_W-1:0]   nphy_wdata,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                en_we,
    input  logic                en_wdata,
    input  logic                ser_in,
    output logic                bit_strobe,
    output logic                ir_out,
    output logic [WORD_W-1:0]   phy_cur,
    output logic [WORD_W-1:0]   status
);
    logic [WORD_W-1:0] nphy_q;
    logic              tx_en_q;
    logic              tx_inv_q;
    logic              run;
    logic              clr;
    logic              unit_end;
    logic [IDX_W-1:0]  unit_idx;
    logic              pulse_on;

    sir_cfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .nphy_we    (nphy_we),
        .nphy_wdata (nphy_wdata),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .en_we      (en_we),
        .en_wdata   (en_wdata),
        .nphy_q     (nphy_q),
        .phy_cur    (phy_cur),
        .tx_en      (tx_en_q),
        .tx_inv     (tx_inv_q),
        .status     (status)
    );

    assign run = status[S_SIR] && tx_en_q;

    sir_unit_timer #(.BIT_UNITS(BIT_UNITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .ref_tick (ref_tick),
        .div      (phy_cur[DIV_LSB +: DIV_W]),
        .unit_end (unit_end),
        .unit_idx (unit_idx)
    );

    sir_pulse_fsm #(.BIT_UNITS(BIT_UNITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .ser_in     (ser_in),
        .unit_end   (unit_end),
        .unit_idx   (unit_idx),
        .width      (phy_cur[WID_LSB +: WID_W]),
        .bit_strobe (bit_strobe),
        .pulse_on   (pulse_on),
        .clr        (clr)
    );

    assign ir_out = pulse_on ^ tx_inv_q;
endmodule

// File: rtl/sir_pulse_tx_chk.sv
module sir_pulse_tx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] status,
    input logic [15:0] phy_cur,
    input logic [15:0] nphy_q,
    input logic        ir_out,
    input logic        bit_strobe,
    input logic        tx_inv
);
    AST_CUR_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[15]) |-> phy_cur == $past(nphy_q)); // R2
    AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[15] && $past(status[15])) |-> $stable(phy_cur)); // R2
    AST_ERR_NO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        status[14] |-> status[13:11] == 3'b000); // R4
    AST_STROBE_NEEDS_SIR: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> (status[11] && status[10])); // R6
    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !status[11] |=> ir_out == tx_inv); // R9
    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[8:0] == 9'd0); // R5
endmodule

bind sir_pulse_tx sir_pulse_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .status     (status),
    .phy_cur    (phy_cur),
    .nphy_q     (nphy_q),
    .ir_out     (ir_out),
    .bit_strobe (bit_strobe),
    .tx_inv     (tx_inv_q)
);

// File: tb/sir_pulse_tx_tb.sv
module sir_pulse_tx_tb;
    localparam int UNITS = 5;
    localparam logic [6:0] F_SIR = 7'h01, F_MIR = 7'h02, F_FIR = 7'h04,
                           F_TX = 7'h08, F_RX = 7'h10, F_LOOP = 7'h20, F_INV = 7'h40;

    logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b1;
    logic nphy_we = 1'b0, cfg_we = 1'b0, en_we = 1'b0, en_wdata = 1'b0, ser_in = 1'b1;
    logic [15:0] nphy_wdata = '0;
    logic [6:0]  cfg_wdata = '0;
    logic bit_strobe, ir_out;
    logic [15:0] phy_cur, status;

    sir_pulse_tx #(.BIT_UNITS(UNITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .nphy_we(nphy_we), .nphy_wdata(nphy_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .en_we(en_we), .en_wdata(en_wdata), .ser_in(ser_in),
        .bit_strobe(bit_strobe), .ir_out(ir_out),
        .phy_cur(phy_cur), .status(status)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, tick_period = 1, tcnt = 0;
    bit done = 0;
    string req = "R1";
    bit bits_q[$];

    // behavioural model state
    logic [15:0] m_nphy = '0, m_cur = '0;
    logic [6:0]  m_cfg = '0;
    logic [2:0]  m_mode = '0;
    logic        m_en = 1'b0, m_active = 1'b0, m_b = 1'b1;
    int          m_tk = 0;

    function automatic logic [15:0] exp_status();
        logic err;
        logic [2:0] on;
        logic tx;
        err = m_en && ($countones(m_mode) > 1);
        on  = (m_en && !err) ? m_mode : 3'b000;
        tx  = m_cfg[3];
        return {m_en, err, on[2], on[1], on[0], tx, m_cfg[4] && (!tx || m_cfg[5]), 9'd0};
    endfunction

    function automatic int m_d();
        return int'(m_cur[15:10]) + 1;
    endfunction

    function automatic int m_w();
        return int'(m_cur[9:5]) + 1;
    endfunction

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // caller has set inputs just after a falling edge
    task automatic cycle();
        logic s_run, e_strobe, e_ir;
        ser_in   = (bits_q.size() > 0) ? bits_q[0] : 1'b1;
        ref_tick = (tick_period <= 1) || (tcnt % tick_period == 0);
        tcnt++;
        #8;
        s_run    = exp_status()[11] && m_cfg[3];
        e_strobe = s_run && (!m_active || (ref_tick && m_tk == UNITS * m_d() - 1));
        e_ir     = (m_active && !m_b && m_tk < m_w() * m_d()) ^ m_cfg[6];
        chk("bit_strobe", {15'd0, bit_strobe}, {15'd0, e_strobe});
        chk("ir_out", {15'd0, ir_out}, {15'd0, e_ir});
        chk("status", status, exp_status());
        chk("phy_cur", phy_cur, m_cur);
        if (!s_run) m_active = 1'b0;
        else if (!m_active) begin
            m_active = 1'b1; m_tk = 0; m_b = ser_in;
        end else if (ref_tick) begin
            m_tk++;
            if (m_tk == UNITS * m_d()) begin m_tk = 0; m_b = ser_in; end
        end
        if (e_strobe && bits_q.size() > 0) void'(bits_q.pop_front());
        if (en_we) begin
            if (en_wdata && !m_en) begin m_cur = m_nphy; m_mode = m_cfg[2:0]; end
            m_en = en_wdata;
        end
        if (nphy_we) m_nphy = nphy_wdata;
        if (cfg_we)  m_cfg  = cfg_wdata;
        @(negedge clk);
        nphy_we = 1'b0; cfg_we = 1'b0; en_we = 1'b0;
    endtask

    task automatic run_n(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic wr_nphy(logic [5:0] b, logic [4:0] w, logic [4:0] p);
        nphy_we = 1'b1; nphy_wdata = {b, w, p}; cycle();
    endtask

    task automatic wr_cfg(logic [6:0] v);
        cfg_we = 1'b1; cfg_wdata = v; cycle();
    endtask

    task automatic set_en(logic v);
        en_we = 1'b1; en_wdata = v; cycle();
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset values
        req = "R1";
        chk("reset ir_out", {15'd0, ir_out}, 16'd0);
        chk("reset strobe", {15'd0, bit_strobe}, 16'd0);
        chk("reset status", status, 16'd0);
        chk("reset phy_cur", phy_cur, 16'd0);
        rst_n = 1'b1;
        run_n(2);

        // R2 apply on edge, R6/R7 basic bits, PREAMB nonzero has no effect
        req = "R2";
        wr_nphy(6'd0, 5'd2, 5'd9);
        wr_cfg(F_SIR | F_TX);
        run_n(2);
        set_en(1'b1);
        req = "R7";
        bits_q = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
        run_n(40);

        // R10: divisor 2 with sparse ref_tick
        req = "R10";
        set_en(1'b0);
        wr_nphy(6'd1, 5'd1, 5'd0);
        set_en(1'b1);
        tick_period = 3;
        bits_q = '{1'b0, 1'b1, 1'b0};
        run_n(120);
        tick_period = 1;

        // R8: width beyond bit period
        req = "R8";
        set_en(1'b0);
        wr_nphy(6'd0, 5'd7, 5'd0);
        set_en(1'b1);
        bits_q = '{1'b0, 1'b0, 1'b1, 1'b0};
        run_n(30);

        // R9: live inversion
        req = "R9";
        wr_cfg(F_SIR | F_TX | F_INV);
        bits_q = '{1'b0, 1'b1, 1'b0};
        run_n(20);
        wr_cfg(F_SIR | F_INV);
        run_n(4);
        wr_cfg(F_SIR | F_TX);

        // R2: pending write while enabled is not applied until next edge
        req = "R2";
        wr_nphy(6'd2, 5'd3, 5'd1);
        run_n(10);
        set_en(1'b0);
        set_en(1'b1);
        run_n(3);

        // R11: drop transmit enable mid pulse
        req = "R11";
        bits_q = '{1'b0};
        run_n(5);
        wr_cfg(F_SIR);
        run_n(10);
        bits_q.delete();

        // R4: mode clash
        req = "R4";
        set_en(1'b0);
        wr_cfg(F_SIR | F_MIR | F_TX);
        set_en(1'b1);
        bits_q = '{1'b0, 1'b0};
        run_n(20);
        bits_q.delete();

        // R3: other modes, mode bits latched only at the edge
        req = "R3";
        set_en(1'b0);
        wr_cfg(F_MIR | F_TX);
        set_en(1'b1);
        run_n(4);
        wr_cfg(F_SIR | F_TX);
        run_n(4);
        set_en(1'b0);
        wr_cfg(F_FIR | F_TX);
        set_en(1'b1);
        run_n(4);

        // R5: enable status combinations
        req = "R5";
        wr_cfg(F_RX);
        run_n(2);
        wr_cfg(F_RX | F_TX);
        run_n(2);
        wr_cfg(F_RX | F_TX | F_LOOP);
        run_n(2);
        wr_cfg(F_LOOP);
        run_n(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule